// File: doc/BRIEF.md
# SPI-Triggered Window Watchdog

This block supervises a microcontroller with a two-phase window watchdog. Each supervision cycle is a closed window followed by an open window of equal length. The controller must service the watchdog by sending a serial command word whose trigger flag is set, and that word must land inside the open window. Servicing too early (inside the closed window) is a fault. Failing to service before the open window runs out is also a fault.

Commands reach the block as complete 16-bit words, each qualified by a one-cycle strobe that marks the chip-select rising edge. Time is measured in pulses of a nominal timebase tick. Oscillator tolerance is not modelled. On a fault the block raises a one-cycle error request at once, which feeds the error latch. After a further half window it drives a reset request for a fixed hold time, and it then restarts with a full closed window. The watchdog is off after reset. It can be enabled and disabled only by dedicated command codes. Supervision begins only once the power-on reset delay has completed.

Top module: `spi_window_wdog`

## Requirements
- R1: After reset the watchdog is disabled, `err_req` and `rst_req` are low, and no event occurs (trigger words included) until an enable command is accepted.
- R2: An enable command is a word with bit 9 = 1 and bits 0, 14, 15 = 0. When it is accepted while `por_done` is low, the first closed window starts in the cycle in which `por_done` is first seen high.
- R3: The closed window and the open window each last W = BASE_TICKS << code ticks. The code is taken from bits 13:12.
- R4: A trigger is a strobed word with bit 15 = 1. A trigger seen in the open window, including the open window's last tick, starts a new full closed window and raises no error.
- R5: A trigger seen in the closed window, including the closed window's last tick, is a fault.
- R6: If no trigger arrives by the last tick of the open window, that is a fault. Strobed words with bit 15 = 0 never count as triggers.
- R7: `err_req` is high for exactly one cycle, in the cycle after the clock edge at which the fault is detected.
- R8: `rst_req` rises W/2 ticks after the fault edge and stays high for RES_TICKS ticks. A full closed window then starts.
- R9: The window code is loaded from an accepted enable, or from a trigger that is valid in the open window. It applies from the next closed window onward, and the fault half-window uses the code in force at that time.
- R10: A disable command is a word with bit 14 = 1 and bits 0, 9, 15 = 0. It stops supervision at once and drops `rst_req` on the next edge. Enable commands are ignored for (BASE_TICKS/48 + 1) << code ticks after the disable.
- R11: The window and delay counters advance only on cycles where `tick` is high.
- R12: During the fault delay and the reset hold, triggers and all commands other than disable are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase pulse; one count per high cycle |
| por_done | input | 1 | High once the power-on reset delay has expired |
| cmd_stb | input | 1 | One-cycle strobe: a complete command word was committed on chip-select rise |
| cmd_word | input | 16 | Committed command word |
| err_req | output | 1 | One-cycle fault pulse to the error latch |
| rst_req | output | 1 | Reset request to the reset generator |

## Verification
The bench drives several kinds of stimulus: well-timed triggers at the first and last open-window ticks, and a pretrigger on the last closed-window tick. It also sends status-read words with the trigger flag clear, and a trigger that carries a new window code and lands where the old length would have allowed it. The edge-tick triggers separate a correct window boundary from an off-by-one error. The status reads show whether the trigger bit alone is decoded. The code-change trigger shows whether the new length really applies to the next closed window. A gap in the tick stream, and disable/enable pairs sent inside and just past the drain interval, test the timebase gating and the re-enable guard. A disable sent during the reset hold tests that the reset request drops at once.

// File: rtl/wdg_pkg.sv
// Package: shared types and command-word field positions for the window watchdog.
// Assumes 16-bit command words whose bit 15 is the service flag.
package wdg_pkg;

    localparam int CMD_W      = 16;
    localparam int BIT_TRIG   = 15;  // service flag
    localparam int BIT_MODE_A = 14;  // disable marker
    localparam int BIT_MODE_B = 9;   // enable marker
    localparam int BIT_MODE_C = 0;   // must be zero for enable/disable
    localparam int CODE_LSB   = 12;  // window code field base

    typedef enum logic [2:0] {
        WD_OFF      = 3'd0,
        WD_DRAIN    = 3'd1,
        WD_WAIT_POR = 3'd2,
        WD_CLOSED   = 3'd3,
        WD_OPEN     = 3'd4,
        WD_FAULT_DLY= 3'd5,
        WD_RST_HOLD = 3'd6
    } wd_state_t;

endpackage

// File: rtl/wdg_cmd_decode.sv
// Module: wdg_cmd_decode
// Splits a strobed command word into service, enable and disable requests
// plus the window-length code. Purely combinational; it assumes the strobe
// is one cycle wide per committed word.
module wdg_cmd_decode
    import wdg_pkg::*;
#(
    parameter int CODE_W = 2
) (
    input  logic                 cmd_stb,
    input  logic [CMD_W-1:0]     cmd_word,
    output logic                 trig_o,
    output logic                 en_o,
    output logic                 dis_o,
    output logic [CODE_W-1:0]    code_o
);

    logic modes_clear;

    // Decode the request type from the marker bits.
    always_comb begin
        modes_clear = ~cmd_word[BIT_TRIG] & ~cmd_word[BIT_MODE_C];
        trig_o = cmd_stb & cmd_word[BIT_TRIG];
        en_o   = cmd_stb & modes_clear & cmd_word[BIT_MODE_B] & ~cmd_word[BIT_MODE_A];
        dis_o  = cmd_stb & modes_clear & cmd_word[BIT_MODE_A] & ~cmd_word[BIT_MODE_B];
        code_o = cmd_word[CODE_LSB +: CODE_W];
    end

endmodule

// File: rtl/wdg_tick_timer.sv
// Module: wdg_tick_timer
// Counts timebase ticks up to a limit supplied by the controller.
// done is high on the tick that completes the interval. clear restarts the
// count from zero. It assumes the limit is at least 1 and that the limit
// only changes together with clear.
module wdg_tick_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Terminal-count detect on the completing tick.
    always_comb begin
        done = tick && (cnt_q == (limit - CNT_W'(1)));
    end

    // Tick counter with restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
        end
    end

    a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/wdg_window_fsm.sv
// Module: wdg_window_fsm
// Sequences the watchdog through its states: disabled, drain, waiting for
// power-on reset, closed window, open window, fault delay and reset hold.
// It selects the interval for the shared tick timer and restarts the timer
// on every state change. It assumes at most one of trig/en/dis per cycle.
module wdg_window_fsm
    import wdg_pkg::*;
#(
    parameter int BASE_TICKS = 128,
    parameter int CODE_W     = 2,
    parameter int RES_TICKS  = 8,
    parameter int CNT_W      = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_done,
    input  logic              trig,
    input  logic              en,
    input  logic              dis,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              tmr_done,
    output logic [CNT_W-1:0]  tmr_limit,
    output logic              tmr_clear,
    output logic              err_req,
    output logic              rst_req
);

    localparam int DRAIN_BASE = BASE_TICKS / 48 + 1;
    localparam logic [CNT_W-1:0] BASE_L  = CNT_W'(BASE_TICKS);
    localparam logic [CNT_W-1:0] DRAIN_L = CNT_W'(DRAIN_BASE);
    localparam logic [CNT_W-1:0] RES_L   = CNT_W'(RES_TICKS);

    wd_state_t         st_q, nxt;
    logic [CODE_W-1:0] code_q;
    logic              load_code;
    logic              fault;
    logic [CNT_W-1:0]  win_len;

    // Next-state and fault detection.
    always_comb begin
        nxt       = st_q;
        fault     = 1'b0;
        load_code = 1'b0;
        case (st_q)
            WD_OFF: begin
                if (en) begin
                    load_code = 1'b1;
                    nxt = por_done ? WD_CLOSED : WD_WAIT_POR;
                end
            end
            WD_DRAIN: begin
                if (tmr_done) nxt = WD_OFF;
            end
            WD_WAIT_POR: begin
                if (dis)           nxt = WD_DRAIN;
                else if (por_done) nxt = WD_CLOSED;
            end
            WD_CLOSED: begin
                if (dis) begin
                    nxt = WD_DRAIN;
                end else if (trig) begin
                    fault = 1'b1;
                    nxt   = WD_FAULT_DLY;
                end else if (tmr_done) begin
                    nxt = WD_OPEN;
                end
            end
            WD_OPEN: begin
                if (dis) begin
                    nxt = WD_DRAIN;
                end else if (trig) begin
                    load_code = 1'b1;
                    nxt       = WD_CLOSED;
                end else if (tmr_done) begin
                    fault = 1'b1;
                    nxt   = WD_FAULT_DLY;
                end
            end
            WD_FAULT_DLY: begin
                if (dis)           nxt = WD_DRAIN;
                else if (tmr_done) nxt = WD_RST_HOLD;
            end
            WD_RST_HOLD: begin
                if (dis)           nxt = WD_DRAIN;
                else if (tmr_done) nxt = WD_CLOSED;
            end
            default: nxt = WD_OFF;
        endcase
    end

    // Interval selection for the shared timer.
    always_comb begin
        win_len   = BASE_L << code_q;
        tmr_clear = (nxt != st_q);
        case (st_q)
            WD_DRAIN:     tmr_limit = DRAIN_L << code_q;
            WD_FAULT_DLY: tmr_limit = win_len >> 1;
            WD_RST_HOLD:  tmr_limit = RES_L;
            default:      tmr_limit = win_len;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= WD_OFF;
        else        st_q <= nxt;
    end

    // Window code register, loaded on enable and on valid service.
    always_ff @(posedge clk) begin
        if (!rst_n)         code_q <= '0;
        else if (load_code) code_q <= cmd_code;
    end

    // Registered one-cycle fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) err_req <= 1'b0;
        else        err_req <= fault;
    end

    // Reset request follows the hold state.
    always_comb begin
        rst_req = (st_q == WD_RST_HOLD);
    end

    a_r1_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_OFF) |-> (!err_req && !rst_req));
    a_r2_por_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_WAIT_POR && !por_done && !dis) |=> (st_q == WD_WAIT_POR));
    a_r4_service_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_OPEN && trig) |=> (st_q == WD_CLOSED && !err_req));
    a_r5_early_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_CLOSED && trig) |=> err_req);
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_req |=> !err_req);
    a_r8_reset_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> ($past(st_q) == WD_FAULT_DLY));
    a_r10_disable_drops_reset: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> !rst_req);

endmodule

// File: rtl/spi_window_wdog.sv
// Module: spi_window_wdog (top)
// Window watchdog serviced by committed serial command words. It decodes each
// strobed word, runs the closed/open window sequence on a shared tick
// timer, and issues an immediate error pulse and a delayed reset request
// on faults. It assumes cmd_stb marks the chip-select rising edge.
module spi_window_wdog
    import wdg_pkg::*;
#(
    parameter int BASE_TICKS = 128,
    parameter int CODE_W     = 2,
    parameter int RES_TICKS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             por_done,
    input  logic             cmd_stb,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             err_req,
    output logic             rst_req
);

    localparam int MAX_WIN = BASE_TICKS << ((1 << CODE_W) - 1);
    localparam int MAX_CNT = (MAX_WIN > RES_TICKS) ? MAX_WIN : RES_TICKS;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    logic              trig, en, dis;
    logic [CODE_W-1:0] code;
    logic              tmr_done, tmr_clear;
    logic [CNT_W-1:0]  tmr_limit;

    wdg_cmd_decode #(.CODE_W(CODE_W)) u_dec (
        .cmd_stb  (cmd_stb),
        .cmd_word (cmd_word),
        .trig_o   (trig),
        .en_o     (en),
        .dis_o    (dis),
        .code_o   (code)
    );

    wdg_window_fsm #(
        .BASE_TICKS (BASE_TICKS),
        .CODE_W     (CODE_W),
        .RES_TICKS  (RES_TICKS),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_done  (por_done),
        .trig      (trig),
        .en        (en),
        .dis       (dis),
        .cmd_code  (code),
        .tmr_done  (tmr_done),
        .tmr_limit (tmr_limit),
        .tmr_clear (tmr_clear),
        .err_req   (err_req),
        .rst_req   (rst_req)
    );

    wdg_tick_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .clear (tmr_clear),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

endmodule

// File: tb/spi_window_wdog_tb_top.sv
// Scoreboard bench: stimulus tasks queue the expected output events and
// their cycles, and a negedge monitor pops and compares them.
module spi_window_wdog_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 48;
    localparam int RES        = 6;
    localparam int WATCHDOG   = 100000;

    localparam int EV_ERR = 0;
    localparam int EV_ON  = 1;
    localparam int EV_OFF = 2;

    typedef struct {
        int    kind;
        int    at;
        string req;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        por_done = 1'b0;
    logic        cmd_stb = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        err_req, rst_req;

    int  cyc = 0;
    int  checks = 0;
    int  fails = 0;
    logic prev_rst = 1'b0;
    ev_t exp_q[$];

    spi_window_wdog #(.BASE_TICKS(BASE), .CODE_W(2), .RES_TICKS(RES)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .por_done (por_done),
        .cmd_stb  (cmd_stb),
        .cmd_word (cmd_word),
        .err_req  (err_req),
        .rst_req  (rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic string kname(input int k);
        return (k == EV_ERR) ? "err" : ((k == EV_ON) ? "rst_on" : "rst_off");
    endfunction

    task automatic push_ev(input int k, input int at, input string req);
        ev_t e;
        e.kind = k; e.at = at; e.req = req;
        exp_q.push_back(e);
    endtask

    // Queue a fault at edge f with window w; returns the restart edge.
    task automatic expect_fault(input int f, input int w, input string req, output int restart);
        push_ev(EV_ERR, f, {req, " R7"});
        push_ev(EV_ON,  f + w/2, {req, " R8"});
        push_ev(EV_OFF, f + w/2 + RES, {req, " R8"});
        restart = f + w/2 + RES;
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Send a word so that edge p samples it (called at a negedge).
    task automatic send_at(input int p, input logic [15:0] w);
        wait_until(p - 1);
        cmd_word = w;
        cmd_stb  = 1'b1;
        @(negedge clk);
        cmd_stb  = 1'b0;
        cmd_word = '0;
    endtask

    task automatic check_quiet(input string req);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d events still pending, expected 0", req, exp_q.size());
        end
    endtask

    // Monitor: compare observed events against the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (err_req)              mon_event(EV_ERR);
            if (rst_req && !prev_rst) mon_event(EV_ON);
            if (!rst_req && prev_rst) mon_event(EV_OFF);
        end
        prev_rst <= rst_req;
    end

    task automatic mon_event(input int k);
        ev_t e;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R1 R10 R12: got %s at %0d, expected no event", kname(k), cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != k || e.at != cyc) begin
                fails++;
                $display("FAIL %s: got %s at %0d, expected %s at %0d",
                         e.req, kname(k), cyc, kname(e.kind), e.at);
            end
        end
    endtask

    initial begin : watchdog_proc
        wait (cyc >= WATCHDOG);
        fails++;
        $display("FAIL watchdog: got timeout at %0d, expected end of test", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : stim
        int e, e1, e2, e3, e4, t1, t2, t3, t4, d, d2, q, f, dummy;
        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (err_req !== 1'b0) begin fails++; $display("FAIL R1: got err_req=%b, expected 0", err_req); end
        checks++;
        if (rst_req !== 1'b0) begin fails++; $display("FAIL R1: got rst_req=%b, expected 0", rst_req); end
        rst_n = 1'b1;
        // R1: disabled by default, trigger words have no effect
        send_at(cyc + 10, 16'h8000);
        send_at(cyc + 100, 16'h9000);
        wait_until(cyc + 300);
        check_quiet("R1");

        // R2: enable while POR pending, window starts on por_done
        send_at(cyc + 5, 16'h0200);
        wait_until(cyc + 100);
        por_done = 1'b1;
        e = cyc + 1;
        expect_fault(e + 2*BASE, BASE, "R2 R3 R6", e1);
        // R6: status reads with the trigger bit clear do not count
        send_at(e + 60, 16'h0001);
        send_at(e + 70, 16'h3000);
        // R12: trigger during fault delay is ignored (code 1 not loaded)
        send_at(e + 2*BASE + 4, 16'h9000);

        // R4: service on first and last open-window ticks
        t1 = e1 + BASE + 1;
        send_at(t1, 16'h8000);
        t2 = t1 + 2*BASE;
        send_at(t2, 16'h8000);
        // R5: pretrigger on last closed-window tick
        t3 = t2 + BASE;
        expect_fault(t3, BASE, "R5", e2);
        send_at(t3, 16'h8000);

        // R9: service with code 1, then a trigger where the old length allows it
        t4 = e2 + 70;
        send_at(t4, 16'h9000);
        expect_fault(t4 + 2*BASE, 2*BASE, "R9 R5", e3);
        send_at(t4 + 2*BASE, 16'h8000);

        // R11: 40 missing ticks stretch the next closed window
        wait_until(e3 + 10);
        tick = 1'b0;
        wait_until(e3 + 50);
        tick = 1'b1;
        expect_fault(e3 + 4*BASE + 40, 2*BASE, "R11 R9 R6", e4);

        // R10: disable, enable inside drain is ignored
        d = e4 + 20;
        send_at(d, 16'h4000);
        send_at(d + 4, 16'h0200);
        wait_until(d + 300);
        check_quiet("R10");

        // R10: re-enable right after drain (code 0, drain 2) is accepted
        q = cyc + 1;
        send_at(q, 16'h0200);
        d2 = q + 30;
        send_at(d2, 16'h4000);
        send_at(d2 + 3, 16'h0200);
        f = d2 + 3 + 2*BASE;
        push_ev(EV_ERR, f, "R10 R6 R7");
        push_ev(EV_ON, f + BASE/2, "R10 R8");
        push_ev(EV_OFF, f + BASE/2 + 2, "R10");
        // R10: disable during reset hold drops it at once
        send_at(f + BASE/2 + 2, 16'h4000);
        wait_until(cyc + 300);
        check_quiet("R10 R12");
        dummy = 0;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule